// File: doc/BRIEF.md
# Diagnostic Panel Capture with Sticky Events and Freeze

This block feeds an on-screen diagnostic panel. It gathers 64 one-cycle event strobes into flags that stay set until reset. It also raises some flags itself. It watches a program counter, a melody address and an audio bit, and flags a change in any of them. It watches a CPU stage code and flags each stage code it sees. The block packs three sets of live state into panels of eight 8-bit rows: CPU state, melody-generator state and core state. The event flags form a fourth panel. A 2-bit select chooses which of the four panels drives the output rows.

A freeze input keeps the panel still so that it can be read by eye. On the rising edge of freeze, the block takes a snapshot of all four panels at once. While freeze stays high, the output comes from that snapshot, whichever panel is selected. Event flags keep accumulating underneath during a freeze. Dropping freeze returns the output to live values. Raising freeze again takes a new snapshot.

The output rows are numbered 0 to 7. Bit b of row r shows event flag 8·r+b. Within a row, bit 0 is the leftmost cell on screen.

Top module: `diag_panel_capture`

## Requirements
- R1: `rst` is synchronous and active high. It clears every event flag, the freeze state and the snapshot store. An event strobe in the same cycle as reset does not set its flag. While reset is held with view 0 selected, the rows read all zero.
- R2: A high on `evt_in[i]` at a clock edge sets flag i from that edge onward. The flag stays set until reset. With view 0 selected, flag i appears at bit i%8 of row i/8.
- R3: A program counter change sets flag 23 (row 2, bit 7). A change means that, at a clock edge with `ce` high, `cpu_pc` differs from its value at the previous `ce`-high edge. The first `ce`-high edge after reset only records a baseline and raises no change flag.
- R4: Under the same rule as R3, a change of `mel_addr` sets flag 14 (row 1, bit 6). A change of `aud_bit` sets flag 15 (row 1, bit 7).
- R5: At a clock edge with `ce` high, a stage code k from 0 to 6 on `cpu_stage` sets flag 24+k. Code 6 is the halt stage and has its own flag, 30. Codes 7 to 15 set no flag.
- R6: `view_sel` chooses the panel: 0 for events, 1 for CPU, 2 for melody, 3 for core.
- R7: The CPU panel is built as follows, with each row byte written MSB first:
  - row 0 = {`cpu_id`, `cpu_stage`}
  - row 1 = `cpu_pc[11:4]`
  - row 2 = {`cpu_pc[3:0]`, `cpu_op[7:4]`}
  - row 3 = {`cpu_op[3:0]`, `cpu_acc`}
  - rows 4 to 7 = bytes 0 to 3 of `cpu_aux`
- R8: The melody panel has `mel_addr` in row 0, `mel_data` in row 1, and bytes 0 to 5 of `mel_aux` in rows 2 to 7. The core panel has byte r of `core_state` in row r.
- R9: At a clock edge where `freeze` is high and was low at the previous edge, all four panels are captured. After that edge, and while freeze stays high, the rows show the captured copy of the selected panel. This holds even if the inputs or `view_sel` change.
- R10: At an edge where `freeze` is low, the output returns to live values. A later rising edge of freeze takes a new snapshot.
- R11: Event strobes and change detection keep setting flags while frozen. These flags appear once freeze is released.
- R12: When `ce` is low, no change detection and no stage sampling occur, and the stored baseline is held. External strobes still set flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for change detection and stage sampling |
| evt_in | input | 64 | One-cycle event strobes, one per flag |
| view_sel | input | 2 | Panel select |
| freeze | input | 1 | Hold the display at a snapshot |
| cpu_id | input | 4 | CPU variant code |
| cpu_stage | input | 4 | CPU execution stage code |
| cpu_pc | input | 12 | Program counter |
| cpu_op | input | 8 | Current opcode |
| cpu_acc | input | 4 | Accumulator |
| cpu_aux | input | 32 | Further CPU state, rows 4 to 7 |
| mel_addr | input | 8 | Melody address |
| mel_data | input | 8 | Melody data |
| mel_aux | input | 48 | Further melody state, rows 2 to 7 |
| aud_bit | input | 1 | Audio output bit |
| core_state | input | 64 | Core state, one byte per row |
| row_bytes | output | 8x8 | Panel rows, row r in bits 8r+7 to 8r |

## Verification
Two functions can act in the same cycle: capturing a snapshot and updating the flags. On the rising edge of freeze, the snapshot must hold the flags as they were before that edge. A strobe arriving in the same edge must be absent from the frozen panel, yet appear once freeze is released. The bench raises freeze together with event strobes and program counter changes, both in directed steps and in random runs where freeze toggles. A reference model in the bench applies the capture before the flag update, and every output sample is compared against that model.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int ROWS          = 8;
    localparam int ROW_W         = 8;
    localparam int FLAGS         = ROWS * ROW_W;
    localparam int NIB           = 4;
    localparam int PC_W          = 12;
    localparam int OP_W          = 8;
    localparam int MEL_W         = 8;
    localparam int STAGE_W       = 4;
    localparam int N_VIEWS       = 4;
    localparam int VSEL_W        = $clog2(N_VIEWS);

    // Fixed CPU rows occupy 0..3, the rest come from the aux vector.
    localparam int CPU_FIXED     = 4;
    localparam int CPU_AUX_W     = (ROWS - CPU_FIXED) * ROW_W;
    localparam int MEL_FIXED     = 2;
    localparam int MEL_AUX_W     = (ROWS - MEL_FIXED) * ROW_W;

    // Positions of internally generated flags.
    localparam int F_MEL_CHG     = 14;
    localparam int F_AUD_TGL     = 15;
    localparam int F_PC_CHG      = 23;
    localparam int F_STAGE0      = 24;
    localparam int N_STAGE_FLAGS = 7;
    localparam int STAGE_HALT    = 6;

    typedef enum logic [VSEL_W-1:0] {
        VIEW_EVENTS = 2'd0,
        VIEW_CPU    = 2'd1,
        VIEW_MELODY = 2'd2,
        VIEW_CORE   = 2'd3
    } view_e;

    typedef logic [ROWS-1:0][ROW_W-1:0] panel_t;
    typedef panel_t [N_VIEWS-1:0]       panel_set_t;

    typedef struct packed {
        logic [NIB-1:0]       id;
        logic [STAGE_W-1:0]   stage;
        logic [PC_W-1:0]      pc;
        logic [OP_W-1:0]      op;
        logic [NIB-1:0]       acc;
        logic [CPU_AUX_W-1:0] aux;
    } cpu_live_t;

    typedef struct packed {
        logic [MEL_W-1:0]     addr;
        logic [MEL_W-1:0]     data;
        logic [MEL_AUX_W-1:0] aux;
    } mel_live_t;

    // Signals watched for change events.
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [MEL_W-1:0] mel;
        logic             aud;
    } watch_t;

    function automatic panel_t pack_cpu(cpu_live_t c);
        panel_t p;
        p[0] = {c.id, c.stage};
        p[1] = c.pc[PC_W-1:NIB];
        p[2] = {c.pc[NIB-1:0], c.op[OP_W-1:NIB]};
        p[3] = {c.op[NIB-1:0], c.acc};
        for (int r = CPU_FIXED; r < ROWS; r++) begin
            p[r] = c.aux[ROW_W*(r-CPU_FIXED) +: ROW_W];
        end
        return p;
    endfunction

    function automatic panel_t pack_mel(mel_live_t m);
        panel_t p;
        p[0] = m.addr;
        p[1] = m.data;
        for (int r = MEL_FIXED; r < ROWS; r++) begin
            p[r] = m.aux[ROW_W*(r-MEL_FIXED) +: ROW_W];
        end
        return p;
    endfunction

endpackage

// File: rtl/diag_event_latch.sv
module diag_event_latch
    import diag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [FLAGS-1:0]     evt_in,
    input  watch_t               watch,
    input  logic [STAGE_W-1:0]   stage,
    output logic [FLAGS-1:0]     flags_q
);

    watch_t                   prev_q;
    logic                     prev_valid_q;
    logic [N_STAGE_FLAGS-1:0] stage_hit;
    logic [FLAGS-1:0]         internal_evt;

    for (genvar k = 0; k < N_STAGE_FLAGS; k++) begin : g_stage
        assign stage_hit[k] = ce && (stage == STAGE_W'(k));
    end

    always_comb begin
        internal_evt = '0;
        if (ce && prev_valid_q) begin
            internal_evt[F_PC_CHG]  = (watch.pc  != prev_q.pc);
            internal_evt[F_MEL_CHG] = (watch.mel != prev_q.mel);
            internal_evt[F_AUD_TGL] = (watch.aud != prev_q.aud);
        end
        internal_evt[F_STAGE0 +: N_STAGE_FLAGS] = stage_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q      <= '0;
            prev_q       <= '0;
            prev_valid_q <= 1'b0;
        end else begin
            flags_q <= flags_q | evt_in | internal_evt;
            if (ce) begin
                prev_q       <= watch;
                prev_valid_q <= 1'b1;
            end
        end
    end

    // R1: reset empties every flag on the following edge.
    a_r1_flags_cleared: assert property (@(posedge clk)
        rst |=> (flags_q == '0));

    // R2: a set flag never drops while running.
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q != '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R3: no program counter change flag without a baseline.
    a_r3_no_first_change: assert property (@(posedge clk) disable iff (rst)
        (!prev_valid_q && !evt_in[F_PC_CHG] && !flags_q[F_PC_CHG])
        |=> !flags_q[F_PC_CHG]);

    // R5: the halt stage code raises its own flag.
    a_r5_halt_flag: assert property (@(posedge clk) disable iff (rst)
        (ce && stage == STAGE_W'(STAGE_HALT)) |=> flags_q[F_STAGE0 + STAGE_HALT]);

    // R12: the baseline is held while the enable is low.
    a_r12_baseline_held: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(prev_q));

endmodule

// File: rtl/diag_freeze_snap.sv
module diag_freeze_snap
    import diag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       freeze,
    input  panel_set_t live_all,
    output logic       frozen_q,
    output panel_set_t snap_q
);

    logic capture;

    assign capture = freeze && !frozen_q;

    always_ff @(posedge clk) begin
        if (rst) frozen_q <= 1'b0;
        else     frozen_q <= freeze;
    end

    for (genvar v = 0; v < N_VIEWS; v++) begin : g_view
        always_ff @(posedge clk) begin
            if (rst)          snap_q[v] <= '0;
            else if (capture) snap_q[v] <= live_all[v];
        end
    end

    // R9: a held freeze keeps the snapshot still.
    a_r9_snap_hold: assert property (@(posedge clk) disable iff (rst)
        (freeze && frozen_q) |=> $stable(snap_q));

    // R10: a low freeze leaves the frozen state on the next edge.
    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        !freeze |=> !frozen_q);

    // R9: frozen state follows a rising freeze.
    a_r9_enter: assert property (@(posedge clk) disable iff (rst)
        freeze |=> frozen_q);

endmodule

// File: rtl/diag_view_mux.sv
module diag_view_mux
    import diag_pkg::*;
(
    input  logic [VSEL_W-1:0] view_sel,
    input  logic              frozen,
    input  panel_set_t        live_all,
    input  panel_set_t        snap_all,
    output panel_t            row_bytes
);

    panel_t live_pick;
    panel_t snap_pick;

    assign live_pick = live_all[view_sel];
    assign snap_pick = snap_all[view_sel];
    assign row_bytes = frozen ? snap_pick : live_pick;

endmodule

// File: rtl/diag_panel_capture.sv
module diag_panel_capture
    import diag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce,
    input  logic [FLAGS-1:0]       evt_in,
    input  logic [VSEL_W-1:0]      view_sel,
    input  logic                   freeze,
    input  logic [NIB-1:0]         cpu_id,
    input  logic [STAGE_W-1:0]     cpu_stage,
    input  logic [PC_W-1:0]        cpu_pc,
    input  logic [OP_W-1:0]        cpu_op,
    input  logic [NIB-1:0]         cpu_acc,
    input  logic [CPU_AUX_W-1:0]   cpu_aux,
    input  logic [MEL_W-1:0]       mel_addr,
    input  logic [MEL_W-1:0]       mel_data,
    input  logic [MEL_AUX_W-1:0]   mel_aux,
    input  logic                   aud_bit,
    input  logic [FLAGS-1:0]       core_state,
    output logic [ROWS-1:0][ROW_W-1:0] row_bytes
);

    watch_t      watch;
    cpu_live_t   cpu_live;
    mel_live_t   mel_live;
    logic [FLAGS-1:0] flags;
    panel_set_t  live_all;
    panel_set_t  snap_all;
    logic        frozen;
    panel_t      rows;

    assign watch    = '{pc: cpu_pc, mel: mel_addr, aud: aud_bit};
    assign cpu_live = '{id: cpu_id, stage: cpu_stage, pc: cpu_pc,
                        op: cpu_op, acc: cpu_acc, aux: cpu_aux};
    assign mel_live = '{addr: mel_addr, data: mel_data, aux: mel_aux};

    diag_event_latch u_events (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .evt_in  (evt_in),
        .watch   (watch),
        .stage   (cpu_stage),
        .flags_q (flags)
    );

    assign live_all[VIEW_EVENTS] = flags;
    assign live_all[VIEW_CPU]    = pack_cpu(cpu_live);
    assign live_all[VIEW_MELODY] = pack_mel(mel_live);
    assign live_all[VIEW_CORE]   = core_state;

    diag_freeze_snap u_snap (
        .clk      (clk),
        .rst      (rst),
        .freeze   (freeze),
        .live_all (live_all),
        .frozen_q (frozen),
        .snap_q   (snap_all)
    );

    diag_view_mux u_mux (
        .view_sel  (view_sel),
        .frozen    (frozen),
        .live_all  (live_all),
        .snap_all  (snap_all),
        .row_bytes (rows)
    );

    assign row_bytes = rows;

endmodule

// File: tb/sim_diag_panel_capture.sv
`timescale 1ns/1ps
module sim_diag_panel_capture;

    logic        clk = 1'b0;
    logic        rst, ce, freeze, aud_bit;
    logic [63:0] evt_in, core_state;
    logic [1:0]  view_sel;
    logic [3:0]  cpu_id, cpu_stage, cpu_acc;
    logic [11:0] cpu_pc;
    logic [7:0]  cpu_op, mel_addr, mel_data;
    logic [31:0] cpu_aux;
    logic [47:0] mel_aux;
    logic [7:0][7:0] row_bytes;
    logic [63:0] rows_flat;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [63:0] m_flags, m_snap [4];
    logic [11:0] m_pc;
    logic [7:0]  m_mel;
    logic        m_aud, m_valid, m_fq;

    always #10 clk = ~clk;

    diag_panel_capture u0 (
        .clk(clk), .rst(rst), .ce(ce), .evt_in(evt_in), .view_sel(view_sel),
        .freeze(freeze), .cpu_id(cpu_id), .cpu_stage(cpu_stage), .cpu_pc(cpu_pc),
        .cpu_op(cpu_op), .cpu_acc(cpu_acc), .cpu_aux(cpu_aux), .mel_addr(mel_addr),
        .mel_data(mel_data), .mel_aux(mel_aux), .aud_bit(aud_bit),
        .core_state(core_state), .row_bytes(row_bytes)
    );

    assign rows_flat = row_bytes;

    function automatic logic [63:0] live(input int v, input logic [63:0] fl);
        case (v)
            0:       return fl;                                        // R6
            1:       return {cpu_aux, cpu_op[3:0], cpu_acc, cpu_pc[3:0],
                             cpu_op[7:4], cpu_pc[11:4], cpu_id, cpu_stage}; // R7
            2:       return {mel_aux, mel_data, mel_addr};             // R8
            default: return core_state;                                // R8
        endcase
    endfunction

    task automatic model_edge();
        logic [63:0] inr;
        if (rst) begin
            m_flags = '0; m_valid = 0; m_fq = 0;
            m_pc = '0; m_mel = '0; m_aud = 0;
            for (int v = 0; v < 4; v++) m_snap[v] = '0;
        end else begin
            inr = '0;
            if (ce && m_valid) begin
                inr[23] = (cpu_pc != m_pc);
                inr[14] = (mel_addr != m_mel);
                inr[15] = (aud_bit != m_aud);
            end
            if (ce && cpu_stage < 4'd7) inr[24 + cpu_stage] = 1'b1;
            if (freeze && !m_fq)
                for (int v = 0; v < 4; v++) m_snap[v] = live(v, m_flags);
            m_flags = m_flags | evt_in | inr;
            if (ce) begin
                m_pc = cpu_pc; m_mel = mel_addr; m_aud = aud_bit; m_valid = 1;
            end
            m_fq = freeze;
        end
    endtask

    task automatic step(input string tag);
        logic [63:0] exp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp = m_fq ? m_snap[view_sel] : live(int'(view_sel), m_flags);
        n_chk++;
        if (rows_flat !== exp) begin
            n_bad++;
            $display("FAIL %s: rows=%h expected %h", tag, rows_flat, exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h2c41));
        m_flags = '0; m_fq = 0; m_valid = 0;
        rst = 1; ce = 1; freeze = 1; evt_in = '1; view_sel = 0;
        cpu_id = 4'h3; cpu_stage = 4'd2; cpu_pc = 12'h155; cpu_op = 8'h61;
        cpu_acc = 4'h9; cpu_aux = 32'h0; mel_addr = 8'h22; mel_data = 8'h00;
        mel_aux = '0; aud_bit = 1; core_state = 64'h0;

        // R1: reset wins over strobes and stages, flags read zero
        repeat (3) step("R1");
        view_sel = 1; step("R1");

        // R3: first enabled edge only sets the baseline
        rst = 0; freeze = 0; evt_in = '0; view_sel = 0; cpu_stage = 4'hF;
        cpu_pc = 12'h3AB; mel_addr = 8'h11; aud_bit = 1;
        step("R3");

        // R12: enable low ignores changes and stage codes
        ce = 0; cpu_pc = 12'h3AC; mel_addr = 8'h12; aud_bit = 0; cpu_stage = 4'd3;
        step("R12"); step("R12");
        ce = 1; cpu_pc = 12'h3AB; mel_addr = 8'h11; aud_bit = 1; cpu_stage = 4'hF;
        step("R12");

        // R3: program counter change sets flag 23
        cpu_pc = 12'h3AC; step("R3");
        // R4: melody address change and audio toggle
        mel_addr = 8'h40; step("R4");
        aud_bit = 0;      step("R4");

        // R5: stage codes 0..15, only 0..6 flag
        for (int k = 0; k < 16; k++) begin
            cpu_stage = 4'(k); step("R5");
        end
        cpu_stage = 4'hF;

        // R2: external strobe latches and stays
        evt_in = 64'h1 << 5; step("R2");
        evt_in = '0; step("R2"); step("R2");

        // R6, R7, R8: panel selection and packing
        cpu_id = 4'hA; cpu_pc = 12'hC5E; cpu_op = 8'h7D; cpu_acc = 4'h2;
        cpu_aux = 32'h8421_F00F; mel_data = 8'h5A; mel_aux = 48'h0123_4567_89AB;
        core_state = 64'hFEDC_BA98_7654_3210;
        view_sel = 0; step("R6");
        view_sel = 1; step("R7");
        view_sel = 2; step("R8");
        view_sel = 3; step("R8");

        // R9: freeze captures all panels
        view_sel = 1; freeze = 1; evt_in = 64'h1 << 33; step("R9");
        evt_in = '0; cpu_pc = 12'h001; cpu_aux = 32'h0; core_state = '0; step("R9");
        view_sel = 3; step("R9");
        view_sel = 0; step("R9");
        // R11: events during freeze still latch
        evt_in = 64'h1 << 40; step("R11");
        evt_in = '0; step("R11");
        // R10: release resumes live, re-freeze takes a new copy
        freeze = 0; step("R10");
        core_state = 64'h0BAD_F00D_1234_5678; freeze = 1; view_sel = 3; step("R10");
        core_state = 64'h0; step("R10");
        freeze = 0; step("R10");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            string tag;
            rst      = ($urandom % 500) == 0;
            ce       = ($urandom % 4) != 0;
            evt_in   = (($urandom % 24) == 0) ? (64'h1 << ($urandom % 64)) : 64'h0;
            if (($urandom % 12) == 0) freeze = ~freeze;
            view_sel = 2'($urandom);
            if (($urandom % 8) == 0) cpu_pc = 12'($urandom);
            if (($urandom % 10) == 0) mel_addr = 8'($urandom);
            if (($urandom % 10) == 0) aud_bit = ~aud_bit;
            cpu_stage = 4'($urandom);
            cpu_id = 4'($urandom); cpu_op = 8'($urandom); cpu_acc = 4'($urandom);
            cpu_aux = $urandom; mel_data = 8'($urandom);
            mel_aux = {16'($urandom), $urandom};
            core_state = {$urandom, $urandom};
            if (rst)            tag = "R1";
            else if (m_fq)      tag = "R9";
            else if (view_sel == 0) tag = "R2";
            else if (view_sel == 1) tag = "R7";
            else                tag = "R8";
            step(tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule